// File: doc/BRIEF.md
# Data Phase Detector and Retimer

This block compares a serial data stream against a local clock and reports the phase between them as two pulse trains. One pulse, the error pulse, opens at each data transition and closes at the next rising clock edge, so its width equals the time from the transition to that edge. The other, the reference pulse, always lasts half a clock period. When an external filter averages the difference between the two, it gets a value that is zero when the rising clock edge sits at the centre of each bit, positive when the clock is late, and negative when it is early. The filter's output steers the oscillator that produces the local clock.

The same sampling stages also yield a retimed copy of the data and a recovered clock. At lock the retimed data trails the input by one and a half clock periods, and the recovered clock falls in the middle of each retimed bit. Bits without a transition produce no pulses at all. For this reason the loop gain scales with the transition density of the data: full for a clock-like input, lower for NRZ data. Several lanes that share one clock can be handled in parallel.

Top module: `pd_bangbang_retimer`

## Requirements
- R1: While `rst_n` is low, every sampling stage is clear: `rdata` reads 0 and `ref_pulse` reads 0. Asserting `rst_n` clears `rdata` at once, without a clock edge.
- R2: `err_pulse` is high from a transition on `data_in` until the next rising edge of `clk`. Its width therefore equals the time between the transition and that edge, and while the stages are held in reset it simply follows `data_in`.
- R3: `ref_pulse` goes high at the rising `clk` edge that captures a new data value and goes low at the following falling edge, which is a width of exactly half a clock period. It is never high just before a rising edge.
- R4: Each data transition produces exactly one error pulse and one reference pulse. A bit period with no transition produces neither, including a run of constant data.
- R5: `rdata` takes the value `data_in` had at a rising `clk` edge one full clock period later, at the next rising edge. The data passes a rising-edge stage, then a falling-edge stage, then a rising-edge stage, so with the clock edge at bit centre `rdata` lags `data_in` by 1.5 periods.
- R6: With the default clock mode (value 0, pass-through), `rclk` equals `clk`. `rdata` changes only on rising edges, so the falling edge of `rclk` is at the centre of each retimed bit.
- R7: While `oe_n` is high, `rdata` and `rclk` are released to high impedance. While `oe_n` is low, both are driven.
- R8: The average of (error width minus reference width) is negative with the clock early, zero at bit centre and positive with the clock late. A loop that steps the clock phase by the sign of that difference therefore settles at bit centre.
- R9: Release of `rst_n` is synchronised: the stages stay clear through the first two rising `clk` edges after release, and the third edge is the first capture of `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock from the controlled oscillator |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oe_n | input | 1 | Active-low output enable for `rdata` and `rclk` |
| data_in | input | LANES | Serial data, NRZ or a 50% duty clock |
| err_pulse | output | LANES | Pulse from data transition to next rising clock edge |
| ref_pulse | output | LANES | Half-period pulse following each captured transition |
| rdata | output | LANES | Retimed data, tri-state |
| rclk | output | 1 | Recovered clock, tri-state |

## Verification
The error pulse is combinational from `data_in`, so its width is taken from the input change up to the next rising edge in the same period. The reference pulse follows one edge later and ends half a period after that. Each block of stimulus therefore ends with three constant bits, so that both pulses of the last transition fall inside the measured window before the totals are compared. `rdata` is due at the second rising edge after the data is applied, so the bench samples it half a nanosecond after every rising edge and compares it against the bit it pushed two edges earlier. Reset release is checked edge by edge: there is no capture at the first and second edges, and capture at the third.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  // Polarity of the recovered clock relative to the local clock.
  typedef enum logic {
    RCLK_PASS   = 1'b0,
    RCLK_INVERT = 1'b1
  } rclk_mode_e;

  // Depth of the reset release synchroniser.
  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/pd_rst_sync.sv
`timescale 1ns/1ps
module pd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned N = pd_pkg::RST_SYNC_STAGES;

  logic [N-1:0] chain_q;
  logic [N-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[N-1];

  // R9: internal release only after two edges saw the external reset high
  assert_release_two_edges_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n, 2)
  );
endmodule

// File: rtl/pd_sampler.sv
`timescale 1ns/1ps
module pd_sampler #(
  parameter int unsigned LANES = 1
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [LANES-1:0] data_in,
  output logic [LANES-1:0] q_rise,
  output logic [LANES-1:0] q_fall
);
  logic [LANES-1:0] rise_d;
  logic [LANES-1:0] fall_d;

  always_comb begin
    rise_d = data_in;
    fall_d = q_rise;
  end

  // Data sampled at the rising edge: bit centre at lock.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_rise <= '0;
    else             q_rise <= rise_d;
  end

  // Half a period later the first sample is copied on the falling edge.
  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_fall <= '0;
    else             q_fall <= fall_d;
  end
endmodule

// File: rtl/pd_pulse.sv
`timescale 1ns/1ps
module pd_pulse #(
  parameter int unsigned LANES = 1
) (
  input  logic [LANES-1:0] data_in,
  input  logic [LANES-1:0] q_rise,
  input  logic [LANES-1:0] q_fall,
  output logic [LANES-1:0] err_pulse,
  output logic [LANES-1:0] ref_pulse
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Width depends on where the transition sits relative to the edge.
    assign err_pulse[g] = data_in[g] ^ q_rise[g];
    // Width is fixed at half a period by the two sampling edges.
    assign ref_pulse[g] = q_rise[g] ^ q_fall[g];
  end
endmodule

// File: rtl/pd_retime.sv
`timescale 1ns/1ps
module pd_retime #(
  parameter int unsigned        LANES     = 1,
  parameter pd_pkg::rclk_mode_e RCLK_MODE = pd_pkg::RCLK_PASS
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] q_rise,
  input  logic [LANES-1:0] q_fall,
  output logic [LANES-1:0] rdata,
  output logic             rclk
);
  logic [LANES-1:0] out_d;
  logic [LANES-1:0] out_q;
  logic             clk_fmt;

  always_comb begin
    out_d = q_fall;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= '0;
    else             out_q <= out_d;
  end

  if (RCLK_MODE == pd_pkg::RCLK_INVERT) begin : g_inv
    assign clk_fmt = ~clk;
  end else begin : g_pass
    assign clk_fmt = clk;
  end

  assign rdata = oe_n ? {LANES{1'bz}} : out_q;
  assign rclk  = oe_n ? 1'bz : clk_fmt;

  // R5: output holds what the rising-edge stage held one period before
  assert_retime_lag_R5: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    out_q == $past(q_rise)
  );
endmodule

// File: rtl/pd_bangbang_retimer.sv
`timescale 1ns/1ps
module pd_bangbang_retimer #(
  parameter int unsigned        LANES     = 1,
  parameter pd_pkg::rclk_mode_e RCLK_MODE = pd_pkg::RCLK_PASS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] data_in,
  output logic [LANES-1:0] err_pulse,
  output logic [LANES-1:0] ref_pulse,
  output logic [LANES-1:0] rdata,
  output logic             rclk
);
  logic             rst_sync_n;
  logic [LANES-1:0] q_rise;
  logic [LANES-1:0] q_fall;

  pd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pd_sampler #(.LANES(LANES)) u_smp (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .data_in    (data_in),
    .q_rise     (q_rise),
    .q_fall     (q_fall)
  );

  pd_pulse #(.LANES(LANES)) u_pls (
    .data_in    (data_in),
    .q_rise     (q_rise),
    .q_fall     (q_fall),
    .err_pulse  (err_pulse),
    .ref_pulse  (ref_pulse)
  );

  pd_retime #(.LANES(LANES), .RCLK_MODE(RCLK_MODE)) u_rtm (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .oe_n       (oe_n),
    .q_rise     (q_rise),
    .q_fall     (q_fall),
    .rdata      (rdata),
    .rclk       (rclk)
  );

  // R3: the falling-edge stage has caught up before every rising edge
  assert_ref_low_at_rise_R3: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    ref_pulse == '0
  );

  // R1: both sampling stages are still clear when reset is released
  assert_clear_at_release_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (q_rise == '0 && q_fall == '0)
  );
endmodule

// File: tb/sim_pd_bangbang_retimer.sv
`timescale 1ns/1ps
module sim_pd_bangbang_retimer;
  logic       clk;
  logic       rst_n;
  logic       oe_n;
  logic [0:0] data_in;
  logic [0:0] err_pulse;
  logic [0:0] ref_pulse;
  wire  [0:0] rdata;
  wire        rclk;

  pullup   (rdata[0]);
  pulldown (rclk);

  pd_bangbang_retimer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_n      (oe_n),
    .data_in   (data_in),
    .err_pulse (err_pulse),
    .ref_pulse (ref_pulse),
    .rdata     (rdata),
    .rclk      (rclk)
  );

  int n_checks = 0;
  int n_err    = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Pulse width integrator, samples at x.x5 ns (never on an edge)
  int  ecnt = 0, rcnt = 0, epn = 0, rpn = 0;
  bit  eprev = 1'b0, rprev = 1'b0;
  initial begin
    #0.05;
    forever begin
      #0.1;
      if (err_pulse[0]) ecnt++;
      if (ref_pulse[0]) rcnt++;
      if (err_pulse[0] && !eprev) epn++;
      if (ref_pulse[0] && !rprev) rpn++;
      eprev = err_pulse[0];
      rprev = ref_pulse[0];
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err + 1, n_checks + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0g expected=%0g", req, what, act, exp);
    end
  endtask

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  bit hist [0:4095];
  int gi = 0;

  // One clock period: check the retimed output, then drive the next bit
  // dq quarter-ns before the coming rising edge.
  task automatic step(input int dq, input bit nb);
    @(posedge clk);
    #0.5;
    if (gi >= 2 && !oe_n)
      check(rdata[0] == hist[(gi - 2) % 4096], "R5", "retimed bit",
            rdata[0], hist[(gi - 2) % 4096]);
    check(rclk == 1'b1, "R6", "rclk high after rising edge", rclk, 1);
    #(4.5 - dq * 0.25);
    data_in[0] = nb;
    hist[gi % 4096] = nb;
    gi++;
  endtask

  int  blk_tr;
  real blk_ew, blk_rw;
  int  blk_ep, blk_rp;

  // pat: 0 random, 1 alternating, 2 constant
  task automatic run_block(input int n, input int dq, input int pat);
    int e0, r0, ep0, rp0;
    bit nb;
    e0 = ecnt; r0 = rcnt; ep0 = epn; rp0 = rpn;
    blk_tr = 0;
    for (int i = 0; i < n + 3; i++) begin
      if (i >= n)        nb = data_in[0];
      else if (pat == 0) nb = 1'($urandom_range(0, 1));
      else if (pat == 1) nb = ~data_in[0];
      else               nb = data_in[0];
      if (nb != data_in[0]) blk_tr++;
      step(dq, nb);
    end
    blk_ew = (ecnt - e0) * 0.1;
    blk_rw = (rcnt - r0) * 0.1;
    blk_ep = epn - ep0;
    blk_rp = rpn - rp0;
  endtask

  task automatic eval_block(input int dq);
    real d, tol;
    d   = dq * 0.25;
    tol = 0.1 * blk_tr + 0.2;
    check(blk_ep == blk_tr, "R4", "error pulse count", blk_ep, blk_tr);
    check(blk_rp == blk_tr, "R4", "reference pulse count", blk_rp, blk_tr);
    check(absr(blk_ew - blk_tr * d) <= tol, "R2", "total error width",
          blk_ew, blk_tr * d);
    check(absr(blk_rw - blk_tr * 2.5) <= tol, "R3", "total reference width",
          blk_rw, blk_tr * 2.5);
  endtask

  initial begin
    int unsigned seed_v;
    int dq;
    int blocks;
    bit locked;
    real diff;
    int sweep [3];
    seed_v = $urandom(32'd2024);
    sweep[0] = 4; sweep[1] = 10; sweep[2] = 15;

    // Reset state
    rst_n = 1'b0; oe_n = 1'b0; data_in = 1'b1;
    repeat (3) @(posedge clk);
    #0.5;
    check(rdata[0] == 1'b0, "R1", "rdata in reset", rdata[0], 0);
    check(ref_pulse[0] == 1'b0, "R1", "ref_pulse in reset", ref_pulse[0], 0);
    check(err_pulse[0] == 1'b1, "R2", "err follows data in reset", err_pulse[0], 1);

    // Synchronised release: no capture at edges A and B, capture at C
    @(negedge clk); #0.7; rst_n = 1'b1;
    @(posedge clk); #0.5;
    check(ref_pulse[0] == 1'b0, "R9", "no capture at first edge", ref_pulse[0], 0);
    @(posedge clk); #0.5;
    check(err_pulse[0] == 1'b1, "R9", "no capture at second edge", err_pulse[0], 1);
    @(posedge clk); #0.5;
    check(ref_pulse[0] == 1'b1, "R9", "capture at third edge", ref_pulse[0], 1);
    check(err_pulse[0] == 1'b0, "R2", "err closes at rising edge", err_pulse[0], 0);
    @(posedge clk); #0.5;
    check(rdata[0] == 1'b1, "R5", "rdata one period after capture", rdata[0], 1);

    // Asynchronous clear
    #0.5; rst_n = 1'b0;
    #0.2;
    check(rdata[0] == 1'b0, "R1", "async clear of rdata", rdata[0], 0);
    #0.3; data_in = 1'b0; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Recovered clock and output enable (data held at 0)
    @(posedge clk); #0.5;
    check(rclk == 1'b1, "R6", "rclk high with clk high", rclk, 1);
    @(negedge clk); #0.5;
    check(rclk == 1'b0, "R6", "rclk low with clk low", rclk, 0);
    check(rdata[0] == 1'b0, "R6", "rdata steady over falling edge", rdata[0], 0);
    oe_n = 1'b1; #0.1;
    check(rdata[0] == 1'b1, "R7", "rdata released (pull-up seen)", rdata[0], 1);
    @(posedge clk); #0.5;
    check(rclk == 1'b0, "R7", "rclk released (pull-down seen)", rclk, 0);
    oe_n = 1'b0; #0.2;
    check(rclk == 1'b1, "R7", "rclk driven again", rclk, 1);
    check(rdata[0] == 1'b0, "R7", "rdata driven again", rdata[0], 0);

    // Phase sweep: early, centred, late; random, clock-like, constant data
    gi = 0;
    foreach (sweep[k]) begin
      run_block(40, sweep[k], 0); eval_block(sweep[k]);
      run_block(32, sweep[k], 1); eval_block(sweep[k]);
      check(blk_tr == 32, "R4", "clock pattern density one", blk_tr, 32);
      run_block(16, sweep[k], 2); eval_block(sweep[k]);
      check(blk_ep == 0 && blk_rp == 0, "R4", "no pulses without transitions",
            blk_ep + blk_rp, 0);
    end

    // Closed loop: step the data phase by the sign of the width difference
    dq = 3; locked = 1'b0; blocks = 0;
    while (!locked && blocks < 16) begin
      run_block(24, dq, 0);
      blocks++;
      if (blk_tr > 0) begin
        diff = blk_ew - blk_rw;
        if (diff > 0.15 * blk_tr)       dq--;
        else if (diff < -0.15 * blk_tr) dq++;
        else                            locked = 1'b1;
      end
    end
    check(locked && dq == 10, "R8", "loop settles at bit centre (quarter-ns)",
          dq, 10);

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule